// File: doc/BRIEF.md
# Straight-Line Function-Block Sequencer

The sequencer runs a fixed list of function-block operations once per work cycle. A start strobe begins a walk through an external, read-only program memory from address 0 upward. Each word is fetched, decoded, and then executed against a small internal signal store. Operands come from that store or from a read-only input port. Results either stay in the store, where they persist across cycles, or are written to a separate output store. The program has no branch, jump, loop or interrupt. So the number of clock cycles a work cycle takes depends only on the number of words executed and never on the data.

An end opcode closes the cycle with a one-cycle done pulse. The block checks itself as it goes. It flags and aborts on a word whose check bit is wrong, on an opcode it does not know, on an operand index beyond the store it names, and on a program with no end opcode within the instruction budget. A start strobe that arrives while a cycle is still running is refused and reported as an overrun. Nothing from the block ever writes the program memory or the input signals.

Top module: `fbseq_top`

## Requirements
- R1: During reset and after it, busy, done, fault, pm_req and out_we are low and fault_kind is 0.
- R2: A start strobe while idle fetches words from address 0 in rising order, one word at a time, and pm_req is only ever high while busy.
- R3: Word layout is bit 16 check, bits 15:12 opcode, 11:8 dst, 7:4 srcA, 3:0 srcB. Opcodes are 1 ADD, 2 SUB, 3 AND, 4 OR, 5 XOR (store[dst] = store[srcA] op store[srcB], modulo 2^16), 6 LDI (store[dst] = input[srcA]), 7 STO (output[dst] = store[srcA]) and 8 MOV (store[dst] = store[srcA]).
- R4: Opcode 0 ends the cycle. busy falls and done is high for exactly one cycle while busy is low. The signal store keeps its values into the next cycle.
- R5: With memory data valid one cycle after the request, each executed word, the end word included, takes exactly 3 clock cycles of busy, whatever the data.
- R6: A word whose 17 bits have odd parity aborts the cycle without executing it. fault rises, fault_kind becomes 1 and no done pulse is given.
- R7: Opcodes 9 to 15 abort the cycle with fault_kind 2.
- R8: An index at or above the store it names aborts with fault_kind 3. Store indices must be below 8, input indices below 8 and output indices below 8. No output write ever uses an index of 8 or more.
- R9: If the word at address MAX_INSTR-1 is valid and is not an end word, it is executed and the cycle then aborts with fault_kind 4.
- R10: A start strobe while busy is not honoured. fault rises with fault_kind 5, and the running cycle continues to its normal end with unchanged timing.
- R11: A start strobe accepted while idle clears fault and sets fault_kind to 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_start | input | 1 | Work-cycle start strobe |
| pm_req | output | 1 | Program word request |
| pm_addr | output | PC_W | Program word address |
| pm_data | input | 17 | Program word |
| pm_valid | input | 1 | Program word valid |
| in_sel | output | 4 | Input signal index |
| in_data | input | SIG_W | Selected input signal |
| out_we | output | 1 | Output store write strobe |
| out_addr | output | 4 | Output store index |
| out_data | output | SIG_W | Output store data |
| busy | output | 1 | Work cycle in progress |
| done | output | 1 | One-cycle pulse at a normal cycle end |
| fault | output | 1 | Self-check fault flag |
| fault_kind | output | 3 | Cause of the latest fault |

## Verification
The assertions watch several properties on every cycle. They check that done is a single-cycle pulse seen only while idle, and that a fetch request appears only inside a work cycle. They check that output writes follow a busy cycle and stay inside the output store, and that any end of a cycle without done carries a fault. They also check that a start while busy always sets the fault and that an accepted start always clears it. The exact arithmetic results, the execution order, the three-cycle-per-word timing and its independence from data are shown only by the bench's scenarios. The same holds for the specific fault codes and for the last-slot rule of the instruction budget.

// File: rtl/fbseq_pkg.sv
`timescale 1ns/1ps
package fbseq_pkg;
  localparam int OP_W   = 4;
  localparam int FLD_W  = 4;
  localparam int WORD_W = 1 + OP_W + 3 * FLD_W;

  typedef enum logic [OP_W-1:0] {
    OP_END = 4'd0,
    OP_ADD = 4'd1,
    OP_SUB = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_XOR = 4'd5,
    OP_LDI = 4'd6,
    OP_STO = 4'd7,
    OP_MOV = 4'd8
  } opcode_e;

  typedef struct packed {
    logic             chk;
    logic [OP_W-1:0]  op;
    logic [FLD_W-1:0] dst;
    logic [FLD_W-1:0] sa;
    logic [FLD_W-1:0] sb;
  } pword_t;

  typedef enum logic [2:0] {
    FLT_NONE     = 3'd0,
    FLT_CHECKSUM = 3'd1,
    FLT_OPCODE   = 3'd2,
    FLT_RANGE    = 3'd3,
    FLT_NOEND    = 3'd4,
    FLT_OVERRUN  = 3'd5
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2
  } state_e;

  function automatic logic fits(input logic [FLD_W-1:0] idx, input int unsigned lim);
    return 32'(idx) < lim;
  endfunction
endpackage

// File: rtl/fbseq_decode.sv
`timescale 1ns/1ps
module fbseq_decode
  import fbseq_pkg::*;
#(
  parameter int NSIG = 8,
  parameter int NIN  = 8,
  parameter int NOUT = 8
) (
  input  pword_t word,
  output fault_e err,
  output logic   is_end,
  output logic   wr_reg,
  output logic   wr_out
);
  logic known;
  logic in_range;

  always_comb begin
    known    = 1'b1;
    in_range = 1'b1;
    is_end   = 1'b0;
    wr_reg   = 1'b0;
    wr_out   = 1'b0;
    case (word.op)
      OP_END: is_end = 1'b1;
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: begin
        wr_reg   = 1'b1;
        in_range = fits(word.dst, NSIG) && fits(word.sa, NSIG) && fits(word.sb, NSIG);
      end
      OP_MOV: begin
        wr_reg   = 1'b1;
        in_range = fits(word.dst, NSIG) && fits(word.sa, NSIG);
      end
      OP_LDI: begin
        wr_reg   = 1'b1;
        in_range = fits(word.dst, NSIG) && fits(word.sa, NIN);
      end
      OP_STO: begin
        wr_out   = 1'b1;
        in_range = fits(word.dst, NOUT) && fits(word.sa, NSIG);
      end
      default: known = 1'b0;
    endcase

    if (^word)          err = FLT_CHECKSUM;
    else if (!known)    err = FLT_OPCODE;
    else if (!in_range) err = FLT_RANGE;
    else                err = FLT_NONE;
  end
endmodule

// File: rtl/fbseq_alu.sv
`timescale 1ns/1ps
module fbseq_alu
  import fbseq_pkg::*;
#(
  parameter int SIG_W = 16
) (
  input  logic [OP_W-1:0]  op,
  input  logic [SIG_W-1:0] a,
  input  logic [SIG_W-1:0] b,
  input  logic [SIG_W-1:0] ext,
  output logic [SIG_W-1:0] y
);
  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_LDI:  y = ext;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/fbseq_regfile.sv
`timescale 1ns/1ps
module fbseq_regfile #(
  parameter int NSIG  = 8,
  parameter int SIG_W = 16,
  parameter int FLD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [FLD_W-1:0] waddr,
  input  logic [SIG_W-1:0] wdata,
  input  logic [FLD_W-1:0] ra,
  input  logic [FLD_W-1:0] rb,
  output logic [SIG_W-1:0] qa,
  output logic [SIG_W-1:0] qb
);
  logic [SIG_W-1:0] cells [NSIG];

  for (genvar g = 0; g < NSIG; g++) begin : g_cell
    logic hit;
    assign hit = we && (32'(waddr) == g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cells[g] <= '0;
      else if (hit) cells[g] <= wdata;
    end
  end

  always_comb begin
    qa = '0;
    qb = '0;
    for (int i = 0; i < NSIG; i++) begin
      if (32'(ra) == i) qa = cells[i];
      if (32'(rb) == i) qb = cells[i];
    end
  end
endmodule

// File: rtl/fbseq_ctrl.sv
`timescale 1ns/1ps
module fbseq_ctrl
  import fbseq_pkg::*;
#(
  parameter int MAX_INSTR = 16,
  parameter int SIG_W     = 16,
  parameter int PC_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             pm_valid,
  input  pword_t           pm_word,
  input  fault_e           err,
  input  logic             is_end,
  input  logic             wr_reg,
  input  logic             wr_out,
  input  logic [SIG_W-1:0] alu_y,
  output pword_t           ir,
  output logic             pm_req,
  output logic [PC_W-1:0]  pm_addr,
  output logic             rf_we,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output fault_e           fault_kind,
  output logic             out_we,
  output logic [FLD_W-1:0] out_addr,
  output logic [SIG_W-1:0] out_data
);
  localparam logic [PC_W-1:0] LAST_PC = PC_W'(MAX_INSTR - 1);

  state_e           state_q, state_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic             pc_en, ir_en, flt_en, out_en;
  pword_t           ir_q;
  logic             fault_q, fault_d;
  fault_e           kind_q, kind_d;
  logic             done_q, done_d;
  logic             owe_q, owe_d;
  logic [FLD_W-1:0] oaddr_q;
  logic [SIG_W-1:0] odata_q;

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    pc_en   = 1'b0;
    ir_en   = 1'b0;
    flt_en  = 1'b0;
    fault_d = fault_q;
    kind_d  = kind_q;
    done_d  = 1'b0;
    owe_d   = 1'b0;
    out_en  = 1'b0;
    rf_we   = 1'b0;

    if (start && state_q != ST_IDLE) begin
      flt_en  = 1'b1;
      fault_d = 1'b1;
      kind_d  = FLT_OVERRUN;
    end

    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_FETCH;
          pc_en   = 1'b1;
          pc_d    = '0;
          flt_en  = 1'b1;
          fault_d = 1'b0;
          kind_d  = FLT_NONE;
        end
      end
      ST_FETCH: begin
        if (pm_valid) begin
          ir_en   = 1'b1;
          state_d = ST_EXEC;
        end
      end
      ST_EXEC: begin
        if (err != FLT_NONE) begin
          state_d = ST_IDLE;
          flt_en  = 1'b1;
          fault_d = 1'b1;
          kind_d  = err;
        end else if (is_end) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          rf_we = wr_reg;
          if (wr_out) begin
            owe_d  = 1'b1;
            out_en = 1'b1;
          end
          if (pc_q == LAST_PC) begin
            state_d = ST_IDLE;
            flt_en  = 1'b1;
            fault_d = 1'b1;
            kind_d  = FLT_NOEND;
          end else begin
            pc_en   = 1'b1;
            pc_d    = pc_q + 1'b1;
            state_d = ST_FETCH;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      ir_q    <= '0;
      fault_q <= 1'b0;
      kind_q  <= FLT_NONE;
      done_q  <= 1'b0;
      owe_q   <= 1'b0;
      oaddr_q <= '0;
      odata_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      owe_q   <= owe_d;
      if (pc_en)  pc_q <= pc_d;
      if (ir_en)  ir_q <= pm_word;
      if (flt_en) begin
        fault_q <= fault_d;
        kind_q  <= kind_d;
      end
      if (out_en) begin
        oaddr_q <= ir_q.dst;
        odata_q <= alu_y;
      end
    end
  end

  assign ir         = ir_q;
  assign pm_req     = (state_q == ST_FETCH);
  assign pm_addr    = pc_q;
  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign fault      = fault_q;
  assign fault_kind = kind_q;
  assign out_we     = owe_q;
  assign out_addr   = oaddr_q;
  assign out_data   = odata_q;
endmodule

// File: rtl/fbseq_top.sv
`timescale 1ns/1ps
module fbseq_top
  import fbseq_pkg::*;
#(
  parameter int MAX_INSTR = 16,
  parameter int SIG_W     = 16,
  parameter int NSIG      = 8,
  parameter int NIN       = 8,
  parameter int NOUT      = 8,
  localparam int PC_W     = $clog2(MAX_INSTR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_start,
  output logic              pm_req,
  output logic [PC_W-1:0]   pm_addr,
  input  logic [WORD_W-1:0] pm_data,
  input  logic              pm_valid,
  output logic [FLD_W-1:0]  in_sel,
  input  logic [SIG_W-1:0]  in_data,
  output logic              out_we,
  output logic [FLD_W-1:0]  out_addr,
  output logic [SIG_W-1:0]  out_data,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [2:0]        fault_kind
);
  logic [1:0]       rsync_q;
  logic             core_rst_n;
  pword_t           ir;
  fault_e           dec_err;
  fault_e           kind;
  logic             dec_end, dec_wr_reg, dec_wr_out;
  logic             rf_we;
  logic [SIG_W-1:0] qa, qb, alu_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  fbseq_decode #(.NSIG(NSIG), .NIN(NIN), .NOUT(NOUT)) u_dec (
    .word   (ir),
    .err    (dec_err),
    .is_end (dec_end),
    .wr_reg (dec_wr_reg),
    .wr_out (dec_wr_out)
  );

  fbseq_regfile #(.NSIG(NSIG), .SIG_W(SIG_W), .FLD_W(FLD_W)) u_rf (
    .clk   (clk),
    .rst_n (core_rst_n),
    .we    (rf_we),
    .waddr (ir.dst),
    .wdata (alu_y),
    .ra    (ir.sa),
    .rb    (ir.sb),
    .qa    (qa),
    .qb    (qb)
  );

  fbseq_alu #(.SIG_W(SIG_W)) u_alu (
    .op  (ir.op),
    .a   (qa),
    .b   (qb),
    .ext (in_data),
    .y   (alu_y)
  );

  fbseq_ctrl #(.MAX_INSTR(MAX_INSTR), .SIG_W(SIG_W), .PC_W(PC_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .start      (cyc_start),
    .pm_valid   (pm_valid),
    .pm_word    (pword_t'(pm_data)),
    .err        (dec_err),
    .is_end     (dec_end),
    .wr_reg     (dec_wr_reg),
    .wr_out     (dec_wr_out),
    .alu_y      (alu_y),
    .ir         (ir),
    .pm_req     (pm_req),
    .pm_addr    (pm_addr),
    .rf_we      (rf_we),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .fault_kind (kind),
    .out_we     (out_we),
    .out_addr   (out_addr),
    .out_data   (out_data)
  );

  assign in_sel     = ir.sa;
  assign fault_kind = kind;
endmodule

// File: rtl/fbseq_chk.sv
`timescale 1ns/1ps
module fbseq_chk #(
  parameter int NOUT = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_start,
  input logic       pm_req,
  input logic       busy,
  input logic       done,
  input logic       fault,
  input logic [2:0] fault_kind,
  input logic       out_we,
  input logic [3:0] out_addr
);
  assert_req_in_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pm_req |-> busy);

  assert_write_after_exec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> $past(busy));

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_abort_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !done) |-> fault);

  assert_out_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> (32'(out_addr) < NOUT));

  assert_overrun_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && busy) |=> (fault && fault_kind != 3'd0));

  assert_start_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !busy) |=> (!fault && fault_kind == 3'd0));
endmodule

bind fbseq_top fbseq_chk #(.NOUT(NOUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_start  (cyc_start),
  .pm_req     (pm_req),
  .busy       (busy),
  .done       (done),
  .fault      (fault),
  .fault_kind (fault_kind),
  .out_we     (out_we),
  .out_addr   (out_addr)
);

// File: tb/sim_fbseq_top.sv
`timescale 1ns/1ps
module sim_fbseq_top;
  localparam int MAXI = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pm_req;
  logic [3:0]  pm_addr;
  logic [16:0] pm_data = '0;
  logic        pm_valid = 1'b0;
  logic [3:0]  in_sel;
  logic [15:0] in_data;
  logic        out_we;
  logic [3:0]  out_addr;
  logic [15:0] out_data;
  logic        busy, done, fault;
  logic [2:0]  fault_kind;

  logic [16:0] prog [MAXI];
  logic [15:0] inputs [8];
  logic [15:0] ostore [8];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  fbseq_top #(.MAX_INSTR(MAXI)) u0 (
    .clk(clk), .rst_n(rst_n), .cyc_start(start),
    .pm_req(pm_req), .pm_addr(pm_addr), .pm_data(pm_data), .pm_valid(pm_valid),
    .in_sel(in_sel), .in_data(in_data),
    .out_we(out_we), .out_addr(out_addr), .out_data(out_data),
    .busy(busy), .done(done), .fault(fault), .fault_kind(fault_kind)
  );

  always @(posedge clk) begin
    pm_valid <= pm_req && !pm_valid;
    pm_data  <= prog[pm_addr];
  end

  assign in_data = (in_sel < 4'd8) ? inputs[in_sel[2:0]] : 16'h0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) ostore[i] <= '0;
    end else if (out_we) begin
      ostore[out_addr[2:0]] <= out_data;
    end
  end

  function automatic logic [16:0] mk(input int op, input int d, input int a, input int b);
    logic [15:0] body;
    body = {op[3:0], d[3:0], a[3:0], b[3:0]};
    return {^body, body};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < MAXI; i++) prog[i] = mk(0, 0, 0, 0);
  endtask

  task automatic run(input int ovr_at, output int cyc, output logic saw_done);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (busy && cyc < 5000) begin
      start = (cyc == ovr_at);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    saw_done = done;
    @(negedge clk);
  endtask

  // op, a, b, expected
  localparam logic [51:0] VEC [8] = '{
    {4'd1, 16'h1234, 16'h0FFF, 16'h2233},
    {4'd1, 16'hFFFF, 16'h0002, 16'h0001},
    {4'd2, 16'h0005, 16'h0007, 16'hFFFE},
    {4'd2, 16'h8000, 16'h0001, 16'h7FFF},
    {4'd3, 16'hF0F0, 16'h3C3C, 16'h3030},
    {4'd4, 16'hF000, 16'h000F, 16'hF00F},
    {4'd5, 16'hAAAA, 16'hFFFF, 16'h5555},
    {4'd5, 16'h1234, 16'h1234, 16'h0000}
  };

  task automatic load_arith(input int op);
    clear_prog();
    prog[0] = mk(6, 0, 0, 0);
    prog[1] = mk(6, 1, 1, 0);
    prog[2] = mk(op, 2, 0, 1);
    prog[3] = mk(7, 0, 2, 0);
    prog[4] = mk(0, 0, 0, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL R5 watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    logic sd;
    for (int i = 0; i < 8; i++) inputs[i] = 16'h0;
    clear_prog();

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", {busy, done, fault, pm_req, out_we, fault_kind}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", {busy, done, fault, pm_req, out_we, fault_kind}, 0);

    // R3/R5 vector table
    for (int v = 0; v < 8; v++) begin
      load_arith(int'(VEC[v][51:48]));
      inputs[0] = VEC[v][47:32];
      inputs[1] = VEC[v][31:16];
      run(-1, cyc, sd);
      chk("R3", ostore[0], VEC[v][15:0]);
      chk("R5", cyc, 15);
      chk("R4", {sd, fault}, 2'b10);
    end

    // R2 order, R3 MOV
    clear_prog();
    inputs[2] = 16'h1111;
    inputs[3] = 16'h2222;
    prog[0] = mk(6, 3, 2, 0);
    prog[1] = mk(7, 1, 3, 0);
    prog[2] = mk(6, 3, 3, 0);
    prog[3] = mk(7, 2, 3, 0);
    prog[4] = mk(8, 4, 3, 0);
    prog[5] = mk(7, 3, 4, 0);
    run(-1, cyc, sd);
    chk("R2", ostore[1], 16'h1111);
    chk("R2", ostore[2], 16'h2222);
    chk("R3", ostore[3], 16'h2222);
    chk("R5", cyc, 21);

    // R4 store persists across cycles
    clear_prog();
    prog[0] = mk(7, 4, 4, 0);
    run(-1, cyc, sd);
    chk("R4", ostore[4], 16'h2222);
    chk("R4", sd, 1'b1);

    // R6 bad check bit
    clear_prog();
    prog[0] = mk(6, 5, 2, 0);
    prog[1] = mk(7, 5, 5, 0) ^ 17'h00001;
    run(-1, cyc, sd);
    chk("R6", {fault, fault_kind}, {1'b1, 3'd1});
    chk("R6", sd, 1'b0);
    chk("R6", ostore[5], 16'h0000);
    chk("R6", cyc, 6);

    // R11 accepted start clears fault
    clear_prog();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R11", {fault, fault_kind}, 4'd0);
    while (busy) @(negedge clk);

    // R7 undefined opcodes
    clear_prog();
    prog[0] = mk(9, 0, 0, 0);
    run(-1, cyc, sd);
    chk("R7", {fault, fault_kind, sd}, {1'b1, 3'd2, 1'b0});
    prog[0] = mk(15, 1, 1, 1);
    run(-1, cyc, sd);
    chk("R7", {fault, fault_kind, sd}, {1'b1, 3'd2, 1'b0});

    // R8 operand range
    prog[0] = mk(1, 9, 0, 0);
    run(-1, cyc, sd);
    chk("R8", {fault, fault_kind, sd}, {1'b1, 3'd3, 1'b0});
    prog[0] = mk(6, 0, 8, 0);
    run(-1, cyc, sd);
    chk("R8", {fault, fault_kind, sd}, {1'b1, 3'd3, 1'b0});
    prog[0] = mk(7, 8, 0, 0);
    run(-1, cyc, sd);
    chk("R8", {fault, fault_kind, sd}, {1'b1, 3'd3, 1'b0});

    // R9 missing end word
    for (int i = 0; i < MAXI - 1; i++) prog[i] = mk(8, 0, 0, 0);
    prog[MAXI-1] = mk(7, 6, 4, 0);
    run(-1, cyc, sd);
    chk("R9", {fault, fault_kind, sd}, {1'b1, 3'd4, 1'b0});
    chk("R9", ostore[6], 16'h2222);
    chk("R9", cyc, 3 * MAXI);

    // R10 overrun strobe
    load_arith(1);
    inputs[0] = 16'h0100;
    inputs[1] = 16'h0023;
    run(4, cyc, sd);
    chk("R10", {fault, fault_kind}, {1'b1, 3'd5});
    chk("R10", sd, 1'b1);
    chk("R10", ostore[0], 16'h0123);
    chk("R10", cyc, 15);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule